// File: doc/BRIEF.md
# Per-Pin Input Glitch Filter with Shared Tick Divider

This block cleans up a bank of general-purpose input pins before they reach edge and level interrupt detection. For every pin, a configuration bit turns filtering on or off. A second bit chooses the pace at which that pin is sampled: every cycle of the core clock, or a slower tick.

The slow tick comes from a single divider that all pins share. One divisor value sets it, and the tick period is twice the divisor plus one, in core clock cycles. A filtered pin accepts a new level only after two consecutive samples on its own time base agree. On the fast base, this removes glitches that last a single cycle. On the slow base, it ignores any pulse shorter than one tick period.

The divider counts only while at least one pin selects the slow tick. Changing the divisor restarts it from zero. The register decoding that feeds the three configuration vectors lives outside this block.

Top module: `gpio_glitch_filter`

## Requirements
- R1: A pin whose filter-enable bit is 0 drives its raw input to its filtered output in the same cycle, with no register in the path.
- R2: A pin with filtering on and the slow-select bit at 0 shows a new input level after the second rising clock edge at which that level is present. After the first such edge the output still holds the old level.
- R3: On a fast-sampled filtered pin, an input pulse lasting a single clock cycle never reaches the output.
- R4: With the divisor set to D, the slow tick period is P = 2*(D+1) clock cycles. A slow pin whose input changes together with a divisor write shows the new level exactly after rising edge 2P, counting the edge that captures the write as edge 0.
- R5: A change of divisor value restarts the divider count. No sample is taken at the edge that captures the change, and the next sample falls P edges later.
- R6: While no pin has its slow-select bit set, the divider count is held at zero. When a slow-select bit then rises at edge 0, slow samples fall at edges P-1 and 2P-1, so an input change made together with it shows after edge 2P-1.
- R7: A slow-sampled filtered pin changes its output only at tick edges. Any input pulse shorter than P cycles never reaches the output.
- R8: Pins are independent: a fast-sampled pin keeps the R2 timing while other pins use the slow tick or receive divisor writes.
- R9: During reset, every filtered pin's output is 0, while unfiltered pins still pass their raw inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; also the fast sampling base |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_raw_i | input | NPINS | Raw pin levels |
| filt_en_i | input | NPINS | Per-pin filter enable (1 = filter on) |
| slow_sel_i | input | NPINS | Per-pin time base (1 = divided tick, 0 = every cycle) |
| divisor_i | input | DIV_W | Shared divisor D; tick period 2*(D+1) cycles |
| pin_filt_o | output | NPINS | Filtered pin levels for the interrupt logic |

## Verification
Each result is tied to a fixed edge count from the stimulus:
- The unfiltered path is due within the same cycle.
- A fast filtered pin is due after its second edge.
- A slow pin after a divisor write is due after edge 2P.
- A slow pin after selection from idle is due after edge 2P-1.

The bench applies stimulus on the falling edge and counts rising edges explicitly. It checks the old level one edge before the due edge and the new level at it, so a latency that is one edge short or one edge long fails. It sweeps every divisor value of a 3-bit configuration and computes P arithmetically. Glitch tests check the output at every cycle across three tick periods.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
   // Time base a pin samples on.
   typedef enum logic {
      TB_FAST = 1'b0,
      TB_SLOW = 1'b1
   } tbase_e;

   // Tick period in core cycles for a given divisor.
   function automatic int unsigned tick_period(input int unsigned div);
      return 2 * (div + 1);
   endfunction
endpackage

// File: rtl/dbf_divider.sv
module dbf_divider #(
   parameter int DIV_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);
   localparam int CW = DIV_W + 1;

   logic [DIV_W-1:0] div_q;
   logic [CW-1:0]    cnt_q;
   logic [CW-1:0]    term;
   logic             restart;

   // Last count of a period is 2*D+1, so a period holds 2*(D+1) cycles.
   assign term    = {div_i, 1'b1};
   assign restart = (div_i != div_q);
   assign tick_o  = run_i && !restart && (cnt_q == term);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
         cnt_q <= '0;
      end else begin
         div_q <= div_i;
         if (restart || !run_i || tick_o)
            cnt_q <= '0;
         else
            cnt_q <= cnt_q + 1'b1;
      end
   end

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (cnt_q == '0)); // R6
   AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o); // R4
   AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (div_i != div_q) |=> !tick_o); // R5
endmodule

// File: rtl/dbf_cell.sv
module dbf_cell
   import dbf_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   input  logic en_i,
   input  logic sel_i,
   input  logic tick_i,
   output logic filt_o
);
   tbase_e base;
   logic   sample;
   logic   samp_q;
   logic   filt_q;

   assign base   = tbase_e'(sel_i);
   assign sample = (base == TB_FAST) || tick_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         samp_q <= 1'b0;
         filt_q <= 1'b0;
      end else if (!en_i) begin
         // Track the pin so that turning the filter on causes no jump.
         samp_q <= raw_i;
         filt_q <= raw_i;
      end else if (sample) begin
         samp_q <= raw_i;
         if (raw_i == samp_q)
            filt_q <= raw_i;
      end
   end

   assign filt_o = en_i ? filt_q : raw_i;

   AST_UPD_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en_i) && (filt_q != $past(filt_q))) |-> (filt_q == $past(samp_q))); // R2
   AST_SLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en_i) && $past(sel_i) && !$past(tick_i)) |-> $stable(filt_q)); // R7
endmodule

// File: rtl/gpio_glitch_filter.sv
module gpio_glitch_filter #(
   parameter int NPINS = 32,
   parameter int DIV_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] pin_raw_i,
   input  logic [NPINS-1:0] filt_en_i,
   input  logic [NPINS-1:0] slow_sel_i,
   input  logic [DIV_W-1:0] divisor_i,
   output logic [NPINS-1:0] pin_filt_o
);
   if (NPINS < 1 || NPINS > 64) begin : g_bad_npins
      $error("NPINS must lie in 1..64");
   end
   if (DIV_W < 1 || DIV_W > 32) begin : g_bad_divw
      $error("DIV_W must lie in 1..32");
   end

   logic run;
   logic tick;

   assign run = |slow_sel_i;

   dbf_divider #(.DIV_W(DIV_W)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (run),
      .div_i  (divisor_i),
      .tick_o (tick)
   );

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      dbf_cell u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .raw_i  (pin_raw_i[i]),
         .en_i   (filt_en_i[i]),
         .sel_i  (slow_sel_i[i]),
         .tick_i (tick),
         .filt_o (pin_filt_o[i])
      );
   end
endmodule

// File: tb/tb_gpio_glitch_filter.sv
module tb_gpio_glitch_filter;
   localparam int NP = 4;
   localparam int DW = 3;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [NP-1:0] raw;
   logic [NP-1:0] en;
   logic [NP-1:0] sel;
   logic [DW-1:0] dv;
   logic [NP-1:0] outp;
   int            tests = 0;
   int            fails = 0;

   always #10 clk = ~clk;

   gpio_glitch_filter #(.NPINS(NP), .DIV_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .pin_raw_i(raw), .filt_en_i(en),
      .slow_sel_i(sel), .divisor_i(dv), .pin_filt_o(outp)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic summary;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      #4_000_000;
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
   end

   initial begin
      logic cur;
      logic lvl;
      int   bad;
      rst_n = 1'b0;
      raw = 4'hF; en = 4'b1110; sel = 4'b0100; dv = 3'd7;
      edges(3);
      // R9: filtered pins read 0 in reset, pin 0 passes through
      for (int i = 0; i < NP; i++) chk("R9", outp[i], (i == 0));
      rst_n = 1'b1;
      raw = 4'h0;
      edges(40);
      chk("R9 settle", outp[2], 1'b0);

      // R1: pass-through sweep on unfiltered pin 0
      for (int v = 0; v < 6; v++) begin
         raw[0] = v[0];
         #1;
         chk("R1", outp[0], v[0]);
         edges(1);
      end

      // R2: fast pin takes two edges
      raw[1] = 1'b1;
      edges(1); chk("R2 edge1", outp[1], 1'b0);
      edges(1); chk("R2 edge2", outp[1], 1'b1);
      // R3: one-cycle low pulse is suppressed
      raw[1] = 1'b0;
      edges(1);
      raw[1] = 1'b1;
      bad = 0;
      for (int k = 0; k < 5; k++) begin
         if (outp[1] !== 1'b1) bad++;
         edges(1);
      end
      chk("R3", bad == 0, 1'b1);
      raw[1] = 1'b0;
      edges(3);

      // R4 R5 R8: divisor sweep, change applied with the write
      lvl = 1'b0;
      for (int d = 0; d < 8; d++) begin
         int p;
         p = 2 * (d + 1);
         lvl = ~lvl;
         dv = d[DW-1:0];
         raw[2] = lvl;
         raw[1] = lvl;
         edges(2);
         chk("R8 fast pin", outp[1], lvl);
         chk("R5 early", outp[2], ~lvl);
         edges(2 * p - 2);
         chk("R5 before 2P", outp[2], ~lvl);
         edges(1);
         chk("R4 at 2P", outp[2], lvl);
      end
      cur = lvl;

      // R7: one-cycle pulses on the slow pin, P = 16
      for (int ph = 0; ph < 2; ph++) begin
         raw[2] = ~cur;
         edges(1);
         raw[2] = cur;
         bad = 0;
         for (int k = 0; k < 48; k++) begin
            if (outp[2] !== cur) bad++;
            edges(1);
         end
         chk("R7", bad == 0, 1'b1);
         edges(5);
      end

      // R6: divider idle, then a slow select arrives
      for (int d = 1; d < 4; d += 2) begin
         int p;
         p = 2 * (d + 1);
         sel = 4'b0000;
         edges(4);
         dv = d[DW-1:0];
         edges(5);
         sel[2] = 1'b1;
         raw[2] = ~cur;
         edges(2 * p - 1);
         chk("R6 before 2P-1", outp[2], cur);
         edges(1);
         chk("R6 at 2P-1", outp[2], ~cur);
         cur = ~cur;
      end
      summary();
   end
endmodule